// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two tables. The first holds branch-history shift registers. The second holds 2-bit saturating counters, and the selected history indexes into it. Parameters set the number of history registers and the number of pattern tables, so one structure covers four organisations:

- one global history or per-address histories;
- one shared pattern table or per-address pattern tables.

An optional parameter XORs the history with branch address bits to form the counter index. A mode input swaps the two-level lookup for one of three alternatives: a fixed not-taken answer, a fixed taken answer, or a bimodal table of counters indexed directly by the branch address.

A front end presents a branch PC on the predict side and reads back the taken/not-taken guess in the same cycle. When the branch resolves, the back end presents its PC and actual outcome on the update side. That update trains the counters and shifts the history, and the change is visible from the next clock.

Top module: `bpred_2lev`

## Requirements
- R1: After reset every counter in both tables holds 01 (weakly not-taken) and every history register holds zero, so bimodal and two-level predictions are not-taken for every PC.
- R2: With mode 0 the prediction is not-taken for every PC and table state.
- R3: With mode 1 the prediction is taken for every PC and table state.
- R4: The prediction in modes 2 and 3 is bit 1 of the selected counter. An update adds one on taken and subtracts one on not-taken, saturating at 3 and at 0.
- R5: An update shifts the outcome into bit 0 of the selected history register (1 = taken) and drops the oldest bit.
- R6: The history register is chosen by the low log2(HIST_ENTRIES) bits of the word address (PC bits starting at bit 2). With HIST_ENTRIES = 1 a single global history is used.
- R7: Without XOR, the pattern index has the history as its low HIST_W bits. Above them sit the low log2(PAT_TABLES) word-address bits, and there are none when PAT_TABLES = 1.
- R8: With USE_XOR = 1, the low part of the pattern index is the history XORed with word-address bits [HIST_W-1:0] (PC bits from bit 2). The table-select bits are unchanged.
- R9: Mode 2 uses a bimodal counter table indexed by the low log2(BIMOD_ENTRIES) word-address bits.
- R10: An update takes effect at the next rising clock edge. A prediction made in the same cycle as an update sees the state from before that update.
- R11: Every update trains the history, the pattern counter and the bimodal counter, whatever the mode input is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 not-taken, 1 taken, 2 bimodal, 3 two-level |
| pred_pc | input | PC_W | Branch PC to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A prediction and an update can land in the same cycle, and they can hit the same counter and history entry. The bench provokes this case directly. It drives an update and a lookup of the same PC together, after first steering the bimodal counter so that the pending write flips its top bit. The result passes only if the guess in that cycle reflects the old counter and the guess one clock later reflects the new one.

During the long sweep, updates alternate with full lookups of every PC. Each lookup is judged in both two-level variants, with and without XOR, against an arithmetic model kept in the bench.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

  typedef enum logic [1:0] {
    BP_FORCE_NT = 2'd0,
    BP_FORCE_T  = 2'd1,
    BP_BIMODAL  = 2'd2,
    BP_TWO_LVL  = 2'd3
  } bp_mode_e;

  localparam logic [1:0] CTR_RESET = 2'b01;

  // saturating 2-bit counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] r;
    if (taken) r = (c == 2'd3) ? 2'd3 : c + 2'd1;
    else       r = (c == 2'd0) ? 2'd0 : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/bp_hist_table.sv
`timescale 1ns/1ps
module bp_hist_table #(
  parameter int ENTRIES = 4,
  parameter int W       = 4,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] pr_idx,
  output logic [W-1:0]  pr_hist,
  input  logic [IW-1:0] up_idx,
  output logic [W-1:0]  up_hist,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_hist
);

  logic [W-1:0] regs [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[up_idx] <= wr_hist;
    end
  end

  assign pr_hist = regs[pr_idx];
  assign up_hist = regs[up_idx];

endmodule

// File: rtl/bp_ctr_table.sv
`timescale 1ns/1ps
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] pr_idx,
  output logic [1:0]    pr_ctr,
  input  logic [IW-1:0] up_idx,
  output logic [1:0]    up_ctr,
  input  logic          wr_en,
  input  logic [1:0]    wr_ctr
);

  logic [1:0] ctrs [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctrs[i] <= CTR_RESET;
    end else if (wr_en) begin
      ctrs[up_idx] <= wr_ctr;
    end
  end

  assign pr_ctr = ctrs[pr_idx];
  assign up_ctr = ctrs[up_idx];

endmodule

// File: rtl/bpred_2lev.sv
`timescale 1ns/1ps
module bpred_2lev
  import bp_pkg::*;
#(
  parameter int PC_W          = 32,
  parameter int HIST_ENTRIES  = 4,
  parameter int HIST_W        = 4,
  parameter int PAT_TABLES    = 4,
  parameter bit USE_XOR       = 1'b0,
  parameter int BIMOD_ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int HIW   = (HIST_ENTRIES > 1) ? $clog2(HIST_ENTRIES) : 1;
  localparam int PSW   = (PAT_TABLES > 1) ? $clog2(PAT_TABLES) : 0;
  localparam int PSW_S = (PSW > 0) ? PSW : 1;
  localparam int PIW   = HIST_W + PSW;
  localparam int PDEP  = PAT_TABLES << HIST_W;
  localparam int BIW   = (BIMOD_ENTRIES > 1) ? $clog2(BIMOD_ENTRIES) : 1;

  // word-aligned address bits start at PC bit 2
  function automatic logic [HIW-1:0] hist_sel(input logic [PC_W-1:0] pc);
    return (HIST_ENTRIES > 1) ? pc[2 +: HIW] : '0;
  endfunction

  function automatic logic [PIW-1:0] pat_index(input logic [PC_W-1:0] pc,
                                               input logic [HIST_W-1:0] h);
    logic [HIST_W-1:0] low;
    logic [PIW-1:0]    idx;
    low = USE_XOR ? (h ^ pc[2 +: HIST_W]) : h;
    idx = PIW'(low);
    if (PAT_TABLES > 1) idx = idx | (PIW'(pc[2 +: PSW_S]) << HIST_W);
    return idx;
  endfunction

  function automatic logic [BIW-1:0] bim_index(input logic [PC_W-1:0] pc);
    return (BIMOD_ENTRIES > 1) ? pc[2 +: BIW] : '0;
  endfunction

  function automatic logic [HIST_W-1:0] hist_shift(input logic [HIST_W-1:0] h,
                                                   input logic t);
    return {h[HIST_W-2:0], t};
  endfunction

  // named internal events
  logic              upd_fire;
  logic [HIW-1:0]    pred_hsel, upd_hsel;
  logic [HIST_W-1:0] pred_hist, upd_hist_cur, upd_hist_nxt;
  logic [PIW-1:0]    pat_pred_idx, pat_upd_idx;
  logic [1:0]        pat_pred_ctr, pat_upd_cur, pat_upd_nxt;
  logic [BIW-1:0]    bim_pred_idx, bim_upd_idx;
  logic [1:0]        bim_pred_ctr, bim_upd_cur, bim_upd_nxt;
  logic              unused_pc_bits;

  assign unused_pc_bits = ^{pred_pc, upd_pc};
  assign upd_fire       = upd_valid;

  assign pred_hsel    = hist_sel(pred_pc);
  assign upd_hsel     = hist_sel(upd_pc);
  assign upd_hist_nxt = hist_shift(upd_hist_cur, upd_taken);

  assign pat_pred_idx = pat_index(pred_pc, pred_hist);
  assign pat_upd_idx  = pat_index(upd_pc, upd_hist_cur);
  assign pat_upd_nxt  = ctr_step(pat_upd_cur, upd_taken);

  assign bim_pred_idx = bim_index(pred_pc);
  assign bim_upd_idx  = bim_index(upd_pc);
  assign bim_upd_nxt  = ctr_step(bim_upd_cur, upd_taken);

  generate
    if (HIST_W < 2) begin : g_bad_width
      initial $error("HIST_W must be at least 2");
    end
  endgenerate

  bp_hist_table #(.ENTRIES(HIST_ENTRIES), .W(HIST_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .pr_idx  (pred_hsel),
    .pr_hist (pred_hist),
    .up_idx  (upd_hsel),
    .up_hist (upd_hist_cur),
    .wr_en   (upd_fire),
    .wr_hist (upd_hist_nxt)
  );

  bp_ctr_table #(.DEPTH(PDEP)) u_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .pr_idx (pat_pred_idx),
    .pr_ctr (pat_pred_ctr),
    .up_idx (pat_upd_idx),
    .up_ctr (pat_upd_cur),
    .wr_en  (upd_fire),
    .wr_ctr (pat_upd_nxt)
  );

  bp_ctr_table #(.DEPTH(BIMOD_ENTRIES)) u_bim (
    .clk    (clk),
    .rst_n  (rst_n),
    .pr_idx (bim_pred_idx),
    .pr_ctr (bim_pred_ctr),
    .up_idx (bim_upd_idx),
    .up_ctr (bim_upd_cur),
    .wr_en  (upd_fire),
    .wr_ctr (bim_upd_nxt)
  );

  always_comb begin
    case (bp_mode_e'(mode))
      BP_FORCE_NT: pred_taken = 1'b0;
      BP_FORCE_T:  pred_taken = 1'b1;
      BP_BIMODAL:  pred_taken = bim_pred_ctr[1];
      default:     pred_taken = pat_pred_ctr[1];
    endcase
  end

endmodule

// File: rtl/bp_2lev_chk.sv
`timescale 1ns/1ps
module bp_2lev_chk #(
  parameter int PC_W = 32,
  parameter int W    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic [PC_W-1:0] pred_pc,
  input logic            pred_taken,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [W-1:0]    upd_hist_cur,
  input logic [W-1:0]    upd_hist_nxt,
  input logic [1:0]      pat_upd_cur,
  input logic [1:0]      pat_upd_nxt,
  input logic [1:0]      bim_upd_nxt
);

  AST_FORCE_NT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> !pred_taken); // R2

  AST_FORCE_T: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> pred_taken); // R3

  AST_CTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |->
      ((pat_upd_cur == 2'd3) ? (pat_upd_nxt == 2'd3) : (pat_upd_nxt == pat_upd_cur + 2'd1))); // R4

  AST_CTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |->
      ((pat_upd_cur == 2'd0) ? (pat_upd_nxt == 2'd0) : (pat_upd_nxt == pat_upd_cur - 2'd1))); // R4

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_hist_nxt[0] == upd_taken) &&
                  ((upd_hist_nxt >> 1) == (W'(upd_hist_cur << 1) >> 1))); // R5

  AST_UPD_NEXT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(upd_valid) && mode == 2'd2 && pred_pc == $past(upd_pc))
      |-> (pred_taken == $past(bim_upd_nxt[1]))); // R10

endmodule

bind bpred_2lev bp_2lev_chk #(.PC_W(PC_W), .W(HIST_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .pred_pc      (pred_pc),
  .pred_taken   (pred_taken),
  .upd_valid    (upd_valid),
  .upd_pc       (upd_pc),
  .upd_taken    (upd_taken),
  .upd_hist_cur (upd_hist_cur),
  .upd_hist_nxt (upd_hist_nxt),
  .pat_upd_cur  (pat_upd_cur),
  .pat_upd_nxt  (pat_upd_nxt),
  .bim_upd_nxt  (bim_upd_nxt)
);

// File: tb/sim_bpred_2lev.sv
`timescale 1ns/1ps
module sim_bpred_2lev;

  localparam int PCW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     mode = 2'd0;
  logic [PCW-1:0] pred_pc = '0;
  logic           upd_valid = 1'b0;
  logic [PCW-1:0] upd_pc = '0;
  logic           upd_taken = 1'b0;
  logic           pred0, pred1;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // plain indexing: N=2, W=2, C=2, B=4
  bpred_2lev #(.PC_W(PCW), .HIST_ENTRIES(2), .HIST_W(2), .PAT_TABLES(2),
               .USE_XOR(1'b0), .BIMOD_ENTRIES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pred_pc(pred_pc), .pred_taken(pred0),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  // same shape, XOR index
  bpred_2lev #(.PC_W(PCW), .HIST_ENTRIES(2), .HIST_W(2), .PAT_TABLES(2),
               .USE_XOR(1'b1), .BIMOD_ENTRIES(4)) u1 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pred_pc(pred_pc), .pred_taken(pred1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  // reference model
  int hist [2];
  int pat0 [8];
  int pat1 [8];
  int bim  [4];

  function automatic int word(int pc); return pc >> 2; endfunction
  function automatic int hsel(int pc); return word(pc) % 2; endfunction
  function automatic int bsel(int pc); return word(pc) % 4; endfunction
  function automatic int pidx(int pc, int h, bit x);
    int lo;
    lo = x ? (h ^ (word(pc) % 4)) : h;
    return ((word(pc) % 2) * 4) + lo;
  endfunction
  function automatic int sat(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) hist[i] = 0;
    for (int i = 0; i < 8; i++) begin pat0[i] = 1; pat1[i] = 1; end
    for (int i = 0; i < 4; i++) bim[i] = 1;
  endfunction

  function automatic void model_upd(int pc, bit t);
    int h, a, b;
    h = hist[hsel(pc)];
    a = pidx(pc, h, 1'b0);
    b = pidx(pc, h, 1'b1);
    pat0[a] = sat(pat0[a], t);
    pat1[b] = sat(pat1[b], t);
    bim[bsel(pc)] = sat(bim[bsel(pc)], t);
    hist[hsel(pc)] = ((h << 1) | int'(t)) % 4;
  endfunction

  task automatic chk(bit got, bit exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%0h mode=%0d actual=%0b expected=%0b",
               req, pred_pc, mode, got, exp);
    end
  endtask

  task automatic upd(int pc, bit t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = PCW'(pc); upd_taken = t;
    @(posedge clk);
    model_upd(pc, t);
    #1 upd_valid = 1'b0;
  endtask

  // lookup of all eight words in bimodal and two-level modes
  task automatic sweep();
    @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      pred_pc = PCW'(w * 4);
      mode = 2'd2; #1;
      chk(pred0, bim[bsel(w * 4)] >= 2, "R9 R11 bimodal");
      chk(pred1, bim[bsel(w * 4)] >= 2, "R9 R11 bimodal");
      mode = 2'd3; #1;
      chk(pred0, pat0[pidx(w * 4, hist[hsel(w * 4)], 1'b0)] >= 2, "R4 R5 R6 R7 two-level");
      chk(pred1, pat1[pidx(w * 4, hist[hsel(w * 4)], 1'b1)] >= 2, "R4 R5 R6 R8 two-level xor");
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 R2 R3: reset state and static modes
    @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      pred_pc = PCW'(w * 4);
      mode = 2'd0; #1; chk(pred0, 1'b0, "R2"); chk(pred1, 1'b0, "R2");
      mode = 2'd1; #1; chk(pred0, 1'b1, "R3"); chk(pred1, 1'b1, "R3");
      mode = 2'd2; #1; chk(pred0, 1'b0, "R1"); chk(pred1, 1'b0, "R1");
      mode = 2'd3; #1; chk(pred0, 1'b0, "R1"); chk(pred1, 1'b0, "R1");
    end

    // R4 saturation and hysteresis on bimodal word 0, trained under mode 0 (R11)
    mode = 2'd0;
    repeat (5) upd(0, 1'b1);
    @(negedge clk); pred_pc = '0; mode = 2'd2; #1;
    chk(pred0, 1'b1, "R4 R11 saturate high");
    mode = 2'd0;
    upd(0, 1'b0);
    @(negedge clk); mode = 2'd2; #1;
    chk(pred0, 1'b1, "R4 one step from 3");
    repeat (5) upd(0, 1'b0);
    upd(0, 1'b1);
    @(negedge clk); mode = 2'd2; #1;
    chk(pred0, 1'b0, "R4 saturate low then one step");
    sweep();

    // R10: same-cycle update and predict on word 3 (bimodal 1 -> 2)
    upd(12, 1'b0); upd(12, 1'b0); upd(12, 1'b1);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = PCW'(12); upd_taken = 1'b1;
    pred_pc = PCW'(12); mode = 2'd2; #1;
    chk(pred0, 1'b0, "R10 same cycle sees old state");
    @(posedge clk);
    model_upd(12, 1'b1);
    #1 upd_valid = 1'b0;
    @(negedge clk); #1;
    chk(pred0, 1'b1, "R10 visible after next clock");

    // R5..R9, R11: pseudo-random training with full lookup after each update
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mode = lfsr[9:8];
      upd(int'(lfsr[3:0]) * 4, (lfsr[6:4] != 3'd0) ^ lfsr[0]);
      sweep();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule